// File: doc/BRIEF.md
# Overlapping block buffer controller

This block turns a slow, irregular stream of samples into fixed-length output blocks on a fast, free-running read clock. Each sample arrives with a write strobe that has no phase relation to the read clock. The strobe is synchronized into the read domain, and the sample is then stored in a 1024-word circular RAM. Once a programmed number of fresh samples has arrived, the block streams out a read block whose length is programmed separately. Because the read block can be longer than the count of fresh words, older words are read out again ahead of the new ones. This gives the overlapping windows that a windowed frequency transform downstream needs.

The data-valid flag is high only while a word on the output is part of the block. The downstream stage uses it as its write enable. An early-warning flag can be placed at an earlier point in the fill, so that the consumer can get ready. Both lengths and the warning point are taken from the mode pins and the data input bus while reset is held. They stay fixed until the next reset. The write strobe period must be more than two read-clock periods.

Top module: `ovl_block_buf`

## Requirements
- R1: While `rst_ni` is low, the read block length is captured. It is 1024 words when `rd_len_sel_i` = 0, and 32 × (`wr_data_i[4:0]` + 1) when `rd_len_sel_i` = 1. Each block raises `dav_o` for exactly that many read-clock cycles.
- R2: The fresh-word count per block is captured during reset from `new_sel_i`: 0 gives 1024, 1 gives 512, 2 gives 256, and 3 gives 32 × (`wr_data_i[9:5]` + 1). `dav_o` stays low until that many words have been committed since the previous block started.
- R3: The warning point is captured during reset from `warn_sel_i`: 0 gives 1024, 1 gives 512, 2 gives 256, and 3 gives 16 × (`wr_data_i[15:10]` + 1) words. `rmf_o` is low before that many fresh words have been committed and high once they have.
- R4: Each rising edge of `wr_strobe_i` commits exactly one word (the value on `wr_data_i`) to the next circular RAM address. It does so after a two-flop synchronizer, on the read-clock edge after the synchronized rise. A strobe held high does not repeat the write.
- R5: The read clock edge after the commit that completes the fresh-word count presents the first word of the block and raises `dav_o`. If W is the write address just past that last word and L is the read length, the block reads addresses (W − L) mod 1024 up to W − 1 in order. Older words therefore come before the new ones.
- R6: After the last word of a block, `dav_o` falls on the next read-clock edge. No further words are presented until the next block.
- R7: A commit during a readout takes that read-clock cycle. `dav_o` is low in the cycle after the commit edge, and `rd_data_o` holds its value. The readout then resumes without skipping a word.
- R8: `rmf_o` falls on the same read-clock edge on which `dav_o` falls at the end of a block. It has no effect on the data path.
- R9: During and right after reset, `dav_o` and `rmf_o` are low and `rd_data_o` is zero.
- R10: Changes on `rd_len_sel_i`, `new_sel_i` and `warn_sel_i` after reset has been released have no effect on block length, fresh count or warning point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock; every RAM access and every flag change happens on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; configuration is captured while it is low |
| wr_strobe_i | input | 1 | Asynchronous write strobe; its rising edge requests a write |
| wr_data_i | input | 16 | Sample to write; during reset, bits [15:0] carry the configuration fields |
| rd_len_sel_i | input | 1 | Read length select: fixed 1024 or taken from the data bus |
| new_sel_i | input | 2 | Fresh-word count select |
| warn_sel_i | input | 2 | Warning-point select |
| rd_data_o | output | 16 | Word being read out |
| dav_o | output | 1 | Data valid; write enable for the downstream stage |
| rmf_o | output | 1 | Early warning that a block is coming |

## Verification
Some properties are checked on every cycle. After a commit, the valid flag is low and the output word holds. Synchronized write pulses never come on two cycles in a row. The warning flag falls only on the edge where the valid flag falls. The captured read length never changes after reset. The bench scenarios are needed for the rest. They cover the start-address arithmetic, the order of old and new words, the decoding of each selector code and data-bus field, the exact number of valid cycles per block, and the warning threshold. A scoreboard replays the circular memory to cover these.

// File: rtl/ovl_buf_pkg.sv
package ovl_buf_pkg;
  typedef enum logic [1:0] {
    SEL_FULL    = 2'd0,
    SEL_HALF    = 2'd1,
    SEL_QUARTER = 2'd2,
    SEL_PINS    = 2'd3
  } len_sel_e;
endpackage

// File: rtl/ovl_buf_cfg.sv
module ovl_buf_cfg
  import ovl_buf_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter int unsigned RD_UNIT   = 32,
  parameter int unsigned WARN_UNIT = 16,
  localparam int unsigned CW       = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_len_sel_i,
  input  logic [1:0]    new_sel_i,
  input  logic [1:0]    warn_sel_i,
  input  logic [15:0]   pins_i,
  output logic [CW-1:0] rd_len_o,
  output logic [CW-1:0] new_len_o,
  output logic [CW-1:0] warn_len_o
);
  localparam logic [CW-1:0] FULL = CW'(1 << AW);

  function automatic logic [CW-1:0] pick(input logic [1:0] sel, input logic [CW-1:0] fine);
    case (len_sel_e'(sel))
      SEL_FULL:    return FULL;
      SEL_HALF:    return FULL >> 1;
      SEL_QUARTER: return FULL >> 2;
      default:     return fine;
    endcase
  endfunction

  logic [CW-1:0] rd_fine, new_fine, warn_fine;
  assign rd_fine   = CW'((32'(pins_i[4:0])   + 32'd1) * RD_UNIT);
  assign new_fine  = CW'((32'(pins_i[9:5])   + 32'd1) * RD_UNIT);
  assign warn_fine = CW'((32'(pins_i[15:10]) + 32'd1) * WARN_UNIT);

  // captured on every read clock while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_len_o   <= rd_len_sel_i ? rd_fine : FULL;
      new_len_o  <= pick(new_sel_i, new_fine);
      warn_len_o <= pick(warn_sel_i, warn_fine);
    end
  end
endmodule

// File: rtl/ovl_buf_sync.sv
module ovl_buf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign pulse_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ovl_buf_ram.sv
module ovl_buf_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 16,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ovl_buf_ctrl.sv
module ovl_buf_ctrl #(
  parameter int unsigned AW = 10,
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_pulse_i,
  input  logic [CW-1:0] rd_len_i,
  input  logic [CW-1:0] new_len_i,
  input  logic [CW-1:0] warn_len_i,
  output logic [AW-1:0] waddr_o,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          dav_o,
  output logic          rmf_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nx;
  logic [CW-1:0] new_cnt_q, rd_left_q, cnt_nx;
  logic          rd_act_q, dav_q, rmf_q, blk_full;

  assign wr_nx    = wr_ptr_q + AW'(1);
  assign cnt_nx   = new_cnt_q + CW'(1);
  assign blk_full = wr_pulse_i && (cnt_nx == new_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      new_cnt_q <= '0;
      rd_left_q <= '0;
      rd_act_q  <= 1'b0;
      dav_q     <= 1'b0;
      rmf_q     <= 1'b0;
    end else begin
      if (wr_pulse_i) begin
        wr_ptr_q  <= wr_nx;
        new_cnt_q <= blk_full ? '0 : cnt_nx;
      end
      if (blk_full) begin
        // start so that the block ends on the word just written
        rd_act_q  <= 1'b1;
        rd_ptr_q  <= wr_nx - rd_len_i[AW-1:0];
        rd_left_q <= rd_len_i;
        dav_q     <= 1'b0;
      end else if (wr_pulse_i) begin
        dav_q <= 1'b0;  // write steals this read slot
      end else if (rd_act_q) begin
        dav_q     <= 1'b1;
        rd_ptr_q  <= rd_ptr_q + AW'(1);
        rd_left_q <= rd_left_q - CW'(1);
        if (rd_left_q == CW'(1)) rd_act_q <= 1'b0;
      end else begin
        dav_q <= 1'b0;
      end
      if (dav_q && !rd_act_q)                       rmf_q <= 1'b0;
      if (wr_pulse_i && (cnt_nx == warn_len_i))     rmf_q <= 1'b1;
    end
  end

  assign waddr_o = wr_ptr_q;
  assign raddr_o = rd_ptr_q;
  assign re_o    = rd_act_q & ~wr_pulse_i;
  assign dav_o   = dav_q;
  assign rmf_o   = rmf_q;
endmodule

// File: rtl/ovl_block_buf.sv
module ovl_block_buf #(
  parameter int unsigned AW          = 10,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RD_UNIT     = 32,
  parameter int unsigned WARN_UNIT   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_strobe_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_len_sel_i,
  input  logic [1:0]    new_sel_i,
  input  logic [1:0]    warn_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic          dav_o,
  output logic          rmf_o
);
  localparam int unsigned CW = AW + 1;

  logic [CW-1:0] rd_len, new_len, warn_len;
  logic          wr_pulse, re;
  logic [AW-1:0] waddr, raddr;

  ovl_buf_cfg #(.AW(AW), .RD_UNIT(RD_UNIT), .WARN_UNIT(WARN_UNIT)) cfg_i (
    .clk_i, .rst_ni, .rd_len_sel_i, .new_sel_i, .warn_sel_i,
    .pins_i    (wr_data_i[15:0]),
    .rd_len_o  (rd_len),
    .new_len_o (new_len),
    .warn_len_o(warn_len)
  );

  ovl_buf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni,
    .strobe_i(wr_strobe_i),
    .pulse_o (wr_pulse)
  );

  ovl_buf_ctrl #(.AW(AW)) ctrl_i (
    .clk_i, .rst_ni,
    .wr_pulse_i(wr_pulse),
    .rd_len_i  (rd_len),
    .new_len_i (new_len),
    .warn_len_i(warn_len),
    .waddr_o   (waddr),
    .re_o      (re),
    .raddr_o   (raddr),
    .dav_o     (dav_o),
    .rmf_o     (rmf_o)
  );

  ovl_buf_ram #(.AW(AW), .DW(DW)) ram_i (
    .clk_i, .rst_ni,
    .we_i   (wr_pulse),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/ovl_block_buf_chk.sv
module ovl_block_buf_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_pulse_i,
  input logic          dav_i,
  input logic          rmf_i,
  input logic [DW-1:0] rd_data_i,
  input logic [CW-1:0] rd_len_i
);
  a_r7_dav_low_after_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_i |=> !dav_i);

  a_r7_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dav_i |-> $stable(rd_data_i));

  a_r4_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_i |=> !wr_pulse_i);

  a_r8_rmf_falls_with_dav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rmf_i) |-> $fell(dav_i));

  a_r10_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_len_i));
endmodule

bind ovl_block_buf ovl_block_buf_chk #(.DW(DW), .CW(AW + 1)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_pulse_i(wr_pulse),
  .dav_i     (dav_o),
  .rmf_i     (rmf_o),
  .rd_data_i (rd_data_o),
  .rd_len_i  (rd_len)
);

// File: tb/ovl_block_buf_tb_top.sv
`timescale 1ns/1ps
module ovl_block_buf_tb_top;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_len_sel = 1'b0;
  logic [1:0]  new_sel = '0;
  logic [1:0]  warn_sel = '0;
  logic [15:0] rd_data;
  logic        dav, rmf;

  int n_tests = 0;
  int n_fail  = 0;
  int dav_cnt = 0;

  logic [15:0] ref_mem [DEPTH];
  bit          ref_vld [DEPTH];
  logic [16:0] sb_q [$];
  int wp = 0, cnt = 0, cur_rl = 0, cur_nl = 0;

  always #2 clk = ~clk;  // 250 MHz

  ovl_block_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_strobe_i(wr_strobe), .wr_data_i(wr_data),
    .rd_len_sel_i(rd_len_sel), .new_sel_i(new_sel), .warn_sel_i(warn_sel),
    .rd_data_o(rd_data), .dav_o(dav), .rmf_o(rmf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected word per valid cycle
  always @(negedge clk) begin
    if (rst_n && dav) begin
      dav_cnt++;
      if (sb_q.size() == 0) chk(1'b0, "R6 word outside block", 1, 0);
      else begin
        logic [16:0] it;
        it = sb_q.pop_front();
        if (it[16]) chk(rd_data === it[15:0], "R4/R5 block word", int'(rd_data), int'(it[15:0]));
      end
    end
  end

  task automatic do_reset(input logic rs, input logic [1:0] ns, input logic [1:0] ws,
                          input logic [15:0] pins, input int rl, input int nl);
    @(negedge clk);
    rst_n = 1'b0;
    rd_len_sel = rs; new_sel = ns; warn_sel = ws; wr_data = pins;
    wp = 0; cnt = 0; cur_rl = rl; cur_nl = nl; dav_cnt = 0;
    sb_q.delete();
    for (int i = 0; i < DEPTH; i++) ref_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dav === 1'b0 && rmf === 1'b0 && rd_data === 16'h0, "R9 reset state",
        int'({dav, rmf, rd_data}), 0);
  endtask

  // driver: updates the model, pushes a block when the fresh count completes
  task automatic wr_word(input logic [15:0] d);
    wr_data = d;
    ref_mem[wp] = d;
    ref_vld[wp] = 1'b1;
    wp = (wp + 1) % DEPTH;
    cnt++;
    if (cnt == cur_nl) begin
      for (int i = 0; i < cur_rl; i++) begin
        int a;
        a = (wp - cur_rl + i + DEPTH) % DEPTH;
        sb_q.push_back({ref_vld[a], ref_mem[a]});
      end
      cnt = 0;
    end
    wr_strobe = 1'b1;
    repeat (3) @(negedge clk);
    // commit edge has just passed: a pending readout must have paused
    if (sb_q.size() != 0) chk(dav === 1'b0, "R7 slot stolen by write", int'(dav), 0);
    wr_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_cfg(input logic rs, input logic [1:0] ns, input logic [1:0] ws,
                         input logic [15:0] pins, input int rl, input int nl, input int wl,
                         input int nwr, input logic [3:0] tag, input bit disturb);
    do_reset(rs, ns, ws, pins, rl, nl);
    if (disturb) begin  // R10: selectors moved after reset
      rd_len_sel = ~rs; new_sel = 2'd0; warn_sel = 2'd0;
    end
    for (int k = 1; k <= nwr; k++) begin
      wr_word({tag, 12'(k)});
      if (k < nl) chk(dav === 1'b0, "R2 early valid", int'(dav), 0);
      if (k == nl) chk(dav === 1'b1, "R2/R5 block start", int'(dav), 1);
      if (k <= nl) chk(rmf === (k >= wl), "R3 warning point", int'(rmf), int'(k >= wl));
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(dav_cnt == (nwr / nl) * rl, disturb ? "R1/R10 valid cycles" : "R1 valid cycles",
        dav_cnt, (nwr / nl) * rl);
    chk(dav === 1'b0, "R6 valid low after block", int'(dav), 0);
    chk(rmf === 1'b0, "R8 warning cleared with valid", int'(rmf), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // read 64, fresh 32, warn 16, selectors disturbed after reset
    run_cfg(1'b1, 2'd3, 2'd3, 16'h0001, 64, 32, 16, 96, 4'h1, 1'b1);
    // read 1024, fresh 256, warn 256
    run_cfg(1'b0, 2'd2, 2'd2, 16'h0000, 1024, 256, 256, 1024, 4'h2, 1'b0);
    // read 32*(31+1)=1024 from bus, fresh 1024, warn 16*(3+1)=64
    run_cfg(1'b1, 2'd0, 2'd3, 16'h0C1F, 1024, 1024, 64, 1024, 4'h3, 1'b0);
    // read 1024, fresh 512, warn 512
    run_cfg(1'b0, 2'd1, 2'd1, 16'h0000, 1024, 512, 512, 1024, 4'h4, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule